// File: doc/BRIEF.md
# Two-wire serial byte-memory slave

This block is the slave side of a two-wire serial bus (I2C framing) sitting in front of a 2048-byte behavioural memory. A fast system clock oversamples the clock and data lines. A small synchroniser turns them into clean edges and into start and stop events. A protocol engine then recognises a fixed device identifier, gathers an address, and either stores bytes or streams them back. The bus is driven only through an active-high pull-down enable on the data line. That enable is meant to control an open-drain pad.

Writes are staged in a one-page buffer of 16 bytes. They reach the array only when the master ends the transfer with a stop. The block then imitates a nonvolatile programming period and stays deaf to the bus for the whole of it, so a master can poll with address headers until it gets an acknowledge. Every acknowledge the slave gives also raises a single-cycle strobe. A system watchdog can use that strobe as its clear.

Top module: `i2c_mem_slave`

## Requirements
- R1: A transfer begins only at a start, which is a falling data line while the clock is high. A stop is a rising data line while the clock is high, and it returns the slave to idle. Bits clocked without a preceding start get no acknowledge.
- R2: The slave acknowledges a header byte whose upper nibble (bits 7..4) is 1010. Any other header gets no acknowledge, and neither does anything after it until the next start.
- R3: In a write header, bits 3..1 become memory address bits 10..8 and bit 0 = 0 selects write. The next byte supplies address bits 7..0. The slave acknowledges the header, that address byte and every data byte.
- R4: Consecutive write data advance only the low four address bits. A transfer of more than 16 bytes therefore wraps inside its 16-byte page and overwrites the earlier bytes.
- R5: Data reaches the memory only when a stop ends the write. A repeated start discards the bytes buffered so far, and a transfer that writes nothing does not trigger a write period.
- R6: After a stop that commits data, the slave gives no acknowledge and never pulls the data line for WR_CYCLES system cycles. Once that period ends, a header is acknowledged again.
- R7: An internal counter holds the last accessed address plus one. After a write it points one past the last byte written, wrapping within the page. A read header (bit 0 = 1) returns the byte at the counter and ignores its own bits 3..1.
- R8: Read data leaves most significant bit first and changes after clock falling edges. Each master acknowledge (data low on the ninth clock) sends the next byte. A missing acknowledge makes the slave release the line.
- R9: Sequential reads advance all 11 address bits, and the address after 0x7FF is 0x000.
- R10: Every acknowledge the slave gives produces exactly one single-cycle pulse on the watchdog-clear output.
- R11: A stop in the middle of a byte drops the partial byte but still commits the complete bytes before it. A start in the middle of a byte returns the slave to header recognition.
- R12: After reset the data line is released, no clear pulse is present and the address counter is 0.
- R13: The slave changes its pull-down only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull the data line low |
| wdog_clr_o | output | 1 | One-cycle pulse for each acknowledge given |

## Verification
The bench aims at the places where the address pointer moves in different ways. It overruns a page by two bytes, so a design that carried into the upper bits would spill into the next page. It reads across the top of the array, where a page-limited increment would loop back to 0x7F0. It runs a current read after a short rewrite, where a pointer left at the end of the first write would return the wrong byte. It also interrupts transfers: a stop after half a byte catches a design that stores the fragment, and a repeated start after a data byte catches one that commits without a stop or goes busy for nothing. Polling right after a commit shows whether the slave really stays silent, and a header without a start or with a wrong identifier shows whether it answers when it should not.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_BUSY
    } slv_state_e;

    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } smp_regs_t;

endpackage

// File: rtl/i2cmem_sampler.sv
module i2cmem_sampler
    import i2cmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    smp_regs_t smp_d, smp_q;

    always_comb begin
        smp_d       = smp_q;
        smp_d.scl_m = scl_i;
        smp_d.scl_s = smp_q.scl_m;
        smp_d.scl_p = smp_q.scl_s;
        smp_d.sda_m = sda_i;
        smp_d.sda_s = smp_q.sda_m;
        smp_d.sda_p = smp_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_o      = smp_q.scl_s;
    assign sda_o      = smp_q.sda_s;
    assign scl_rise_o = smp_q.scl_s & ~smp_q.scl_p;
    assign scl_fall_o = ~smp_q.scl_s & smp_q.scl_p;
    assign start_o    = smp_q.scl_s & smp_q.scl_p & smp_q.sda_p & ~smp_q.sda_s;
    assign stop_o     = smp_q.scl_s & smp_q.scl_p & ~smp_q.sda_p & smp_q.sda_s;

endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 2500000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_we_i,
    input  logic [PAGE_W-1:0]        buf_idx_i,
    input  logic [7:0]               buf_data_i,
    input  logic                     buf_clr_i,
    input  logic                     commit_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [7:0]               rd_data_o,
    output logic                     busy_o,
    output logic                     has_data_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;
    localparam int HOLD  = (WR_CYCLES < PAGE) ? PAGE : WR_CYCLES;
    localparam int CW    = $clog2(HOLD + 1);
    localparam logic [PAGE_W:0] PAGE_END = (PAGE_W + 1)'(PAGE);

    typedef struct packed {
        logic [PAGE-1:0][7:0]       data;
        logic [PAGE-1:0]            vld;
        logic [ADDR_W-PAGE_W-1:0]   base;
        logic [CW-1:0]              cnt;
        logic [PAGE_W:0]            idx;
    } store_t;

    store_t st_d, st_q;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [7:0]        mem_wd;
    logic [7:0]        mem [DEPTH];

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        mem_wa = '0;
        mem_wd = '0;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.idx < PAGE_END) begin
                if (st_q.vld[st_q.idx[PAGE_W-1:0]]) begin
                    mem_we = 1'b1;
                    mem_wa = {st_q.base, st_q.idx[PAGE_W-1:0]};
                    mem_wd = st_q.data[st_q.idx[PAGE_W-1:0]];
                end
                st_d.vld[st_q.idx[PAGE_W-1:0]] = 1'b0;
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (commit_i) begin
            st_d.cnt  = CW'(HOLD);
            st_d.base = page_i;
            st_d.idx  = '0;
        end else if (buf_clr_i) begin
            st_d.vld = '0;
        end else if (buf_we_i) begin
            st_d.data[buf_idx_i] = buf_data_i;
            st_d.vld[buf_idx_i]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= mem_wd;
    end

    assign rd_data_o  = mem[rd_addr_i];
    assign busy_o     = (st_q.cnt != '0);
    assign has_data_o = |st_q.vld;

    // R5
    mem_we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy_o);

    // R6
    buf_wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_i |-> !busy_o);

endmodule

// File: rtl/i2cmem_fsm.sv
module i2cmem_fsm
    import i2cmem_pkg::*;
#(
    parameter int         ADDR_W = 11,
    parameter int         PAGE_W = 4,
    parameter logic [3:0] DEV_ID = 4'b1010
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic                     scl_rise_i,
    input  logic                     scl_fall_i,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic [7:0]               rd_data_i,
    input  logic                     busy_i,
    input  logic                     has_data_i,
    output logic [ADDR_W-1:0]        rd_addr_o,
    output logic                     buf_we_o,
    output logic [PAGE_W-1:0]        buf_idx_o,
    output logic [7:0]               buf_data_o,
    output logic                     buf_clr_o,
    output logic                     commit_o,
    output logic [ADDR_W-PAGE_W-1:0] page_o,
    output logic                     sda_pull_o,
    output logic                     ack_o
);

    localparam int BLK_W = ADDR_W - 8;

    typedef struct packed {
        slv_state_e         state;
        logic [3:0]         bitcnt;
        logic [7:0]         shreg;
        logic [BLK_W-1:0]   blk;
        logic [ADDR_W-1:0]  addr;
        logic               rw;
        logic               mack;
        logic               pull;
        logic               ack;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.ack   = 1'b0;
        buf_we_o  = 1'b0;
        buf_clr_o = 1'b0;
        commit_o  = 1'b0;
        if (f_q.state == ST_BUSY) begin
            if (!busy_i) f_d.state = ST_IDLE;
        end else if (start_i) begin
            f_d.state  = ST_DEV;
            f_d.bitcnt = '0;
            f_d.pull   = 1'b0;
            buf_clr_o  = 1'b1;
        end else if (stop_i) begin
            f_d.state = ST_IDLE;
            f_d.pull  = 1'b0;
            if (has_data_i) begin
                commit_o  = 1'b1;
                f_d.state = ST_BUSY;
            end
        end else begin
            case (f_q.state)
                ST_DEV, ST_WORD, ST_WDATA: begin
                    if (scl_rise_i && f_q.bitcnt < 4'd8) begin
                        f_d.shreg  = {f_q.shreg[6:0], sda_i};
                        f_d.bitcnt = f_q.bitcnt + 1'b1;
                    end else if (scl_fall_i && f_q.bitcnt == 4'd8) begin
                        f_d.bitcnt = '0;
                        f_d.pull   = 1'b1;
                        f_d.ack    = 1'b1;
                        if (f_q.state == ST_DEV) begin
                            if (f_q.shreg[7:4] == DEV_ID) begin
                                f_d.state = ST_DEV_ACK;
                                f_d.rw    = f_q.shreg[0];
                                if (!f_q.shreg[0]) f_d.blk = f_q.shreg[BLK_W:1];
                            end else begin
                                f_d.state = ST_IDLE;
                                f_d.pull  = 1'b0;
                                f_d.ack   = 1'b0;
                            end
                        end else if (f_q.state == ST_WORD) begin
                            f_d.state = ST_WORD_ACK;
                            f_d.addr  = {f_q.blk, f_q.shreg};
                        end else begin
                            f_d.state  = ST_WDATA_ACK;
                            buf_we_o   = 1'b1;
                            f_d.addr[PAGE_W-1:0] = f_q.addr[PAGE_W-1:0] + 1'b1;
                        end
                    end
                end
                ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall_i) begin
                        f_d.pull   = 1'b0;
                        f_d.bitcnt = '0;
                        if (f_q.state == ST_DEV_ACK && f_q.rw) begin
                            f_d.state = ST_RDATA;
                            f_d.shreg = rd_data_i;
                            f_d.pull  = ~rd_data_i[7];
                            f_d.addr  = f_q.addr + 1'b1;
                        end else if (f_q.state == ST_DEV_ACK) begin
                            f_d.state = ST_WORD;
                        end else begin
                            f_d.state = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall_i) begin
                        if (f_q.bitcnt == 4'd7) begin
                            f_d.state = ST_RACK;
                            f_d.pull  = 1'b0;
                        end else begin
                            f_d.shreg  = {f_q.shreg[6:0], 1'b0};
                            f_d.pull   = ~f_q.shreg[6];
                            f_d.bitcnt = f_q.bitcnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) f_d.mack = ~sda_i;
                    if (scl_fall_i) begin
                        if (f_q.mack) begin
                            f_d.state  = ST_RDATA;
                            f_d.bitcnt = '0;
                            f_d.shreg  = rd_data_i;
                            f_d.pull   = ~rd_data_i[7];
                            f_d.addr   = f_q.addr + 1'b1;
                        end else begin
                            f_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.state <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign rd_addr_o  = f_q.addr;
    assign buf_idx_o  = f_q.addr[PAGE_W-1:0];
    assign buf_data_o = f_q.shreg;
    assign page_o     = f_q.addr[ADDR_W-1:PAGE_W];
    assign sda_pull_o = f_q.pull;
    assign ack_o      = f_q.ack;

    // R13
    pull_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(f_q.pull) || $fell(f_q.pull)) |-> !scl_i);

    // R10
    ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.ack |=> !f_q.ack);

    // R6
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (!f_q.pull && !f_q.ack));

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
    parameter int         ADDR_W    = 11,
    parameter int         PAGE_W    = 4,
    parameter int         WR_CYCLES = 2500000,
    parameter logic [3:0] DEV_ID    = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    output logic wdog_clr_o
);

    logic                     scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0]               rd_data;
    logic                     busy, has_data;
    logic [ADDR_W-1:0]        rd_addr;
    logic                     buf_we, buf_clr, commit;
    logic [PAGE_W-1:0]        buf_idx;
    logic [7:0]               buf_data;
    logic [ADDR_W-PAGE_W-1:0] page;

    i2cmem_sampler u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2cmem_fsm #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .DEV_ID (DEV_ID)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_s),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .rd_data_i  (rd_data),
        .busy_i     (busy),
        .has_data_i (has_data),
        .rd_addr_o  (rd_addr),
        .buf_we_o   (buf_we),
        .buf_idx_o  (buf_idx),
        .buf_data_o (buf_data),
        .buf_clr_o  (buf_clr),
        .commit_o   (commit),
        .page_o     (page),
        .sda_pull_o (sda_pull_o),
        .ack_o      (wdog_clr_o)
    );

    i2cmem_store #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_we_i   (buf_we),
        .buf_idx_i  (buf_idx),
        .buf_data_i (buf_data),
        .buf_clr_i  (buf_clr),
        .commit_i   (commit),
        .page_i     (page),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .busy_o     (busy),
        .has_data_o (has_data)
    );

endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, wdog;
    logic sda_bus;

    int checks = 0, fails = 0, pulses = 0, run = 0, max_run = 0, cyc = 0;
    bit r13_bad = 1'b0;
    logic [7:0] wbuf [20];
    logic [7:0] rbuf [20];

    assign sda_bus = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    i2c_mem_slave #(.WR_CYCLES(400)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .wdog_clr_o (wdog)
    );

    always @(negedge clk) begin
        if (wdog) begin
            pulses++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected=done", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1; wq(2 * Q); scl_m = 0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1; wq(Q); scl_m = 1; wq(Q);
        acked = (sda_bus == 1'b0);
        wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic s0;
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl_m = 1; wq(2);
            s0 = sda_bus;
            wq(2 * Q - 2);
            b[i] = sda_bus;
            if (s0 != b[i]) r13_bad = 1'b1;
            scl_m = 0; wq(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        wq(Q); scl_m = 1; wq(2 * Q); scl_m = 0; wq(Q); sda_m = 1;
    endtask

    task automatic poll_ready(output int polls);
        bit a;
        polls = 0;
        do begin
            bus_start(); send_byte(8'hA0, a); bus_stop(); polls++;
        end while (!a && polls < 40);
    endtask

    // write header, word address and n bytes from wbuf, then stop; returns ack count
    task automatic mem_write(input logic [10:0] addr, input int n, output int acks);
        bit a;
        acks = 0;
        bus_start();
        send_byte({4'hA, addr[10:8], 1'b0}, a); acks += a;
        send_byte(addr[7:0], a); acks += a;
        for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); acks += a; end
        bus_stop();
    endtask

    task automatic write_wait(input logic [10:0] addr, input int n);
        int acks, polls;
        mem_write(addr, n, acks);
        poll_ready(polls);
    endtask

    task automatic rand_read(input logic [10:0] addr, input int n);
        bit a;
        bus_start();
        send_byte({4'hA, addr[10:8], 1'b0}, a);
        send_byte(addr[7:0], a);
        bus_start();
        send_byte({4'hA, 3'b000, 1'b1}, a);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_pull == 1'b0, "R12 pull released after reset", sda_pull, 0);
        check(wdog == 1'b0, "R12 no clear pulse after reset", wdog, 0);
        check(pulses == 0, "R12 no pulses during reset", pulses, 0);
    endtask

    task automatic t_no_start();
        bit a;
        int p0;
        p0 = pulses;
        scl_m = 0; wq(Q);
        send_byte(8'hA0, a);
        bus_stop();
        check(!a, "R1 no ack without start", a, 0);
        check(pulses == p0, "R1 no pulse without start", pulses - p0, 0);
        bus_start(); send_byte(8'hA0, a); bus_stop();
        check(a, "R1 ack after start", a, 1);
    endtask

    task automatic t_bad_id();
        bit a, b;
        int p0;
        p0 = pulses;
        bus_start(); send_byte(8'hB0, a); send_byte(8'h00, b); bus_stop();
        check(!a, "R2 foreign id not acked", a, 0);
        check(!b, "R2 silent until next start", b, 0);
        check(pulses == p0, "R2 no pulse for foreign id", pulses - p0, 0);
    endtask

    task automatic t_write_basic();
        int acks, p0, polls;
        bit a;
        wbuf[0] = 8'h5E;
        write_wait(11'h123, 1);
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC5;
        p0 = pulses;
        mem_write(11'h523, 2, acks);
        check(acks == 4, "R3 header, word and data acked", acks, 4);
        wq(4);
        check(pulses - p0 == 4, "R10 one pulse per ack", pulses - p0, 4);
        check(max_run == 1, "R10 pulse is one cycle wide", max_run, 1);
        // immediate poll must be refused while the write period runs
        bus_start(); send_byte(8'hA0, a); bus_stop();
        check(!a, "R6 no ack during write period", a, 0);
        poll_ready(polls);
        check(polls < 40, "R6 ack returns after write period", polls, 1);
        rand_read(11'h523, 2);
        check(rbuf[0] == 8'h3C, "R3 first byte at block-5 address", rbuf[0], 8'h3C);
        check(rbuf[1] == 8'hC5, "R8 msb-first second byte", rbuf[1], 8'hC5);
        check(sda_pull == 1'b0, "R8 line released after master nack", sda_pull, 0);
        rand_read(11'h123, 1);
        check(rbuf[0] == 8'h5E, "R3 block bits select the page", rbuf[0], 8'h5E);
    endtask

    task automatic t_page_wrap();
        for (int i = 0; i < 18; i++) wbuf[i] = 8'h40 + 8'(i);
        write_wait(11'h20E, 18);
        rand_read(11'h20D, 3);
        check(rbuf[0] == 8'h4F, "R4 wrapped byte at 0x20D", rbuf[0], 8'h4F);
        check(rbuf[1] == 8'h50, "R4 overwritten byte at 0x20E", rbuf[1], 8'h50);
        check(rbuf[2] == 8'h51, "R4 overwritten byte at 0x20F", rbuf[2], 8'h51);
        rand_read(11'h200, 1);
        check(rbuf[0] == 8'h42, "R4 page start after wrap", rbuf[0], 8'h42);
    endtask

    task automatic t_no_commit();
        bit a, b;
        wbuf[0] = 8'h11;
        write_wait(11'h300, 1);
        bus_start();
        send_byte(8'hA6, a); send_byte(8'h00, a); send_byte(8'h99, a);
        bus_start(); send_byte(8'hA6, a);
        bus_stop();
        bus_start(); send_byte(8'hA0, b); bus_stop();
        check(b, "R5 no write period without committed data", b, 1);
        rand_read(11'h300, 1);
        check(rbuf[0] == 8'h11, "R5 repeated start discards data", rbuf[0], 8'h11);
    endtask

    task automatic t_current();
        bit a;
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h11 * 8'(i + 1);
        write_wait(11'h120, 4);
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        write_wait(11'h120, 2);
        bus_start(); send_byte(8'hA7, a); recv_byte(1'b0, rbuf[0]); bus_stop();
        check(a, "R7 read header acked", a, 1);
        check(rbuf[0] == 8'h33, "R7 counter one past last write", rbuf[0], 8'h33);
        bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, rbuf[0]); bus_stop();
        check(rbuf[0] == 8'h44, "R7 counter advanced by read", rbuf[0], 8'h44);
    endtask

    task automatic t_seq_wrap();
        wbuf[0] = 8'hE7;
        write_wait(11'h7FF, 1);
        wbuf[0] = 8'h0A;
        write_wait(11'h000, 1);
        rand_read(11'h7FF, 2);
        check(rbuf[0] == 8'hE7, "R9 last location", rbuf[0], 8'hE7);
        check(rbuf[1] == 8'h0A, "R9 wrap to address 0", rbuf[1], 8'h0A);
    endtask

    task automatic t_abort();
        bit a;
        int polls;
        wbuf[0] = 8'h01; wbuf[1] = 8'h77;
        write_wait(11'h440, 2);
        bus_start();
        send_byte(8'hA8, a); send_byte(8'h40, a); send_byte(8'h5A, a);
        send_bits(8'hFF, 4);
        bus_stop();
        poll_ready(polls);
        check(polls > 1, "R11 complete bytes committed at stop", polls, 2);
        rand_read(11'h440, 2);
        check(rbuf[0] == 8'h5A, "R11 complete byte stored", rbuf[0], 8'h5A);
        check(rbuf[1] == 8'h77, "R11 partial byte dropped", rbuf[1], 8'h77);
        bus_start(); send_bits(8'hA0, 3);
        bus_start(); send_byte(8'hA0, a); bus_stop();
        check(a, "R11 header recognised after mid-byte start", a, 1);
    endtask

    initial begin
        wq(10);
        t_reset();
        rst_n = 1'b1;
        wq(10);
        t_reset();
        t_no_start();
        t_bad_id();
        t_write_basic();
        t_page_wrap();
        t_no_commit();
        t_current();
        t_seq_wrap();
        t_abort();
        check(!r13_bad, "R13 read data stable while clock high", r13_bad, 0);
        summary();
    end

endmodule